// File: doc/BRIEF.md
# Four-bit look-ahead adder with bounded gate fan-in

This block adds two 4-bit operands and a carry-in with no clock. Every carry is worked out from the operands and the carry-in directly, so no carry waits for the one below it to settle. The design has three explicit layers. The first forms a propagate and a generate term for each bit position. The second is a look-ahead carry network. The third forms the sum bits from the propagate terms and the carries.

The carry network is built at gate level as sum-of-products in NAND-NAND form. No gate in it may take more than four inputs. The flat expression for the top carry would need a five-input product and a five-input OR, so that carry is built from two partial terms that are then merged. The carries into bits 1 to 3 are brought out next to the carry-out. A wider adder can chain several of these blocks through the carry-in and the carry-out.

Top module: `cla4_lookahead_adder`

## Requirements
- R1: `sum_o` equals the low four bits of `a_i + b_i + cin_i`, for every one of the 512 input combinations.
- R2: `cout_o` equals bit 4 of `a_i + b_i + cin_i`.
- R3: For k = 1, 2, 3, `carry_o[k-1]` is the carry into bit k. This is bit k of `a_i[k-1:0] + b_i[k-1:0] + cin_i`.
- R4: A bit position where both operand bits are 1 always sends out a carry of 1. The carry out of position i is `carry_o[i]` for i < 3 and `cout_o` for i = 3.
- R5: A bit position where both operand bits are 0 always sends out a carry of 0, whatever carry comes into it.
- R6: A bit position where exactly one operand bit is 1 sends out the same carry that comes into it.
- R7: With both operands zero, `sum_o` equals `{3'b000, cin_i}`, and `cout_o` and all of `carry_o` are 0.
- R8: With every position propagating (`a_i ^ b_i` = 4'b1111), `cout_o` equals `cin_i` and `sum_o` equals `~cin_i` in every bit. This exercises the split form of the top carry.
- R9: No gate in the carry network has more than four inputs. A gate wider than the configured limit stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| carry_o | output | 3 | Carries into bits 1, 2 and 3 (index 0 is the carry into bit 1) |
| cout_o | output | 1 | Carry out of bit 3 |

## Verification
The bench targets the top carry most heavily, because it is built from two partial terms. It drives long propagate chains with a generate at bit 0 or with the carry-in as the only source. A network that dropped the term routed through the low carry would clear `cout_o` for 0101+1010+1, even though the sum bits stay correct. The bench also drives kill positions that sit above a live carry, and zero operands with the carry-in set. A swapped product term or an inverted NAND level would then show up as a wrong internal carry before it reached the sum.

// File: rtl/cla4_pkg.sv
// Shared constants for the four-bit look-ahead adder.
// Assumes: the operand width is fixed at four by the hand-built carry network.
package cla4_pkg;
    localparam int unsigned CLA_WIDTH = 4;  // operand width of one adder block
    localparam int unsigned FANIN_MAX = 4;  // widest gate allowed in the carry network
endpackage

// File: rtl/cla4_nand_gate.sv
// N-input NAND primitive for the carry network.
// Assumes: N lies between 1 and FANIN_MAX; a wider gate stops elaboration (R9).
module cla4_nand_gate
    import cla4_pkg::*;
#(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] din,
    output logic         dout
);
    // fan-in guard: reject any gate wider than the limit (R9)
    if (N > FANIN_MAX || N < 1) begin : g_fanin_violation
        $error("cla4_nand_gate: fan-in %0d is outside 1..%0d", N, FANIN_MAX);
    end

    // NAND of all inputs
    assign dout = ~&din;
endmodule

// File: rtl/cla4_pg_stage.sv
// Per-bit propagate (xor) and generate (and) terms.
// Assumes: operands are valid whenever they are sampled; purely combinational.
module cla4_pg_stage #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // propagate and generate for bit i
        assign prop[i] = a[i] ^ b[i];
        assign gen[i]  = a[i] & b[i];
    end
endmodule

// File: rtl/cla4_carry_net.sv
// Look-ahead carry network in NAND-NAND form, no gate wider than four inputs.
// Each carry is built from propagate/generate terms and the carry-in only.
// The top carry is split in two: a partial OR of G3, P3G2 and P3P2G1, and a
// product P3P2P1 times carry 1 (carry 1 being G0 + P0C0). The two are merged
// by a final NAND.
// Assumes: four bit positions.
module cla4_carry_net (
    input  logic [3:0] prop,
    input  logic [3:0] gen,
    input  logic       cin,
    output logic [4:1] carry
);
    // carry 1 = G0 + P0C0
    logic c1_t0, c1_t1;
    cla4_nand_gate #(.N(1)) u_c1_t0 (.din(gen[0]),            .dout(c1_t0));
    cla4_nand_gate #(.N(2)) u_c1_t1 (.din({prop[0], cin}),    .dout(c1_t1));
    cla4_nand_gate #(.N(2)) u_c1_or (.din({c1_t0, c1_t1}),    .dout(carry[1]));

    // carry 2 = G1 + P1G0 + P1P0C0
    logic c2_t0, c2_t1, c2_t2;
    cla4_nand_gate #(.N(1)) u_c2_t0 (.din(gen[1]),                   .dout(c2_t0));
    cla4_nand_gate #(.N(2)) u_c2_t1 (.din({prop[1], gen[0]}),        .dout(c2_t1));
    cla4_nand_gate #(.N(3)) u_c2_t2 (.din({prop[1], prop[0], cin}),  .dout(c2_t2));
    cla4_nand_gate #(.N(3)) u_c2_or (.din({c2_t0, c2_t1, c2_t2}),    .dout(carry[2]));

    // carry 3 = G2 + P2G1 + P2P1G0 + P2P1P0C0, independent of carry 2
    logic c3_t0, c3_t1, c3_t2, c3_t3;
    cla4_nand_gate #(.N(1)) u_c3_t0 (.din(gen[2]),                            .dout(c3_t0));
    cla4_nand_gate #(.N(2)) u_c3_t1 (.din({prop[2], gen[1]}),                 .dout(c3_t1));
    cla4_nand_gate #(.N(3)) u_c3_t2 (.din({prop[2], prop[1], gen[0]}),        .dout(c3_t2));
    cla4_nand_gate #(.N(4)) u_c3_t3 (.din({prop[2], prop[1], prop[0], cin}),  .dout(c3_t3));
    cla4_nand_gate #(.N(4)) u_c3_or (.din({c3_t0, c3_t1, c3_t2, c3_t3}),      .dout(carry[3]));

    // carry 4, upper partial: G3 + P3G2 + P3P2G1
    logic c4_t0, c4_t1, c4_t2, c4_hi, c4_hi_n;
    cla4_nand_gate #(.N(1)) u_c4_t0 (.din(gen[3]),                     .dout(c4_t0));
    cla4_nand_gate #(.N(2)) u_c4_t1 (.din({prop[3], gen[2]}),          .dout(c4_t1));
    cla4_nand_gate #(.N(3)) u_c4_t2 (.din({prop[3], prop[2], gen[1]}), .dout(c4_t2));
    cla4_nand_gate #(.N(3)) u_c4_hi (.din({c4_t0, c4_t1, c4_t2}),      .dout(c4_hi));
    cla4_nand_gate #(.N(1)) u_c4_hn (.din(c4_hi),                      .dout(c4_hi_n));

    // carry 4, lower partial: P3P2P1 times (G0 + P0C0), inverted
    logic c4_lo_n;
    cla4_nand_gate #(.N(4)) u_c4_lo (.din({prop[3], prop[2], prop[1], carry[1]}), .dout(c4_lo_n));

    // carry 4 merge: upper OR lower
    cla4_nand_gate #(.N(2)) u_c4_or (.din({c4_hi_n, c4_lo_n}), .dout(carry[4]));
endmodule

// File: rtl/cla4_sum_stage.sv
// Sum formation: each sum bit is its propagate term xor the carry into it.
// Assumes: carries are already settled by the look-ahead network.
module cla4_sum_stage #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] carry_in,
    output logic [W-1:0] sum
);
    // bitwise sum
    assign sum = prop ^ carry_in;
endmodule

// File: rtl/cla4_lookahead_adder.sv
// Four-bit look-ahead adder: propagate/generate layer, bounded fan-in carry
// network, sum layer. Purely combinational; there is no clock and no reset.
// Assumes: a wider adder chains blocks through cin_i and cout_o.
module cla4_lookahead_adder
    import cla4_pkg::*;
(
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       cin_i,
    output logic [3:0] sum_o,
    output logic [2:0] carry_o,
    output logic       cout_o
);
    localparam int unsigned W = CLA_WIDTH;

    logic [W-1:0] prop, gen;
    logic [W:1]   carry_hi;
    logic [W:0]   carry_all;

    cla4_pg_stage #(.W(W)) u_pg (.a(a_i), .b(b_i), .prop(prop), .gen(gen));

    cla4_carry_net u_carry (.prop(prop), .gen(gen), .cin(cin_i), .carry(carry_hi));

    // full carry vector: index i is the carry into bit i
    assign carry_all = {carry_hi, cin_i};

    cla4_sum_stage #(.W(W)) u_sum (.prop(prop), .carry_in(carry_all[W-1:0]), .sum(sum_o));

    // bring out the internal carries and the carry-out
    assign carry_o = carry_all[W-1:1];
    assign cout_o  = carry_all[W];

    // per-position carry rules checked against the operand ports
    always_comb begin
        for (int i = 0; i < W; i++) begin
            p_gen_sets_carry_r4: assert (!(a_i[i] && b_i[i]) || carry_all[i+1])
                else $error("R4: carry out of bit %0d not set", i);
            p_kill_clears_carry_r5: assert ((a_i[i] || b_i[i]) || !carry_all[i+1])
                else $error("R5: carry out of bit %0d not cleared", i);
            p_prop_passes_carry_r6: assert (!(a_i[i] ^ b_i[i]) || (carry_all[i+1] == carry_all[i]))
                else $error("R6: carry through bit %0d altered", i);
        end
        p_zero_operands_r7: assert (!(a_i == '0 && b_i == '0) ||
                                    (sum_o == {3'b000, cin_i} && !cout_o && carry_o == '0))
            else $error("R7: zero operands gave a wrong result");
    end
endmodule

// File: tb/cla4_lookahead_adder_bench.sv
// Scoreboard bench: the driver applies inputs at the falling edge and queues
// the expected result; the monitor compares at the next rising edge.
module cla4_lookahead_adder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;  // 100 MHz

    logic [3:0] a_i = '0, b_i = '0, sum_o;
    logic       cin_i = 1'b0, cout_o;
    logic [2:0] carry_o;

    cla4_lookahead_adder u_cla4_lookahead_adder (
        .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
        .sum_o(sum_o), .carry_o(carry_o), .cout_o(cout_o)
    );

    typedef struct {
        logic [3:0] exp_sum;
        logic [2:0] exp_carry;
        logic       exp_cout;
        string      tag;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // carry into bit k, computed from masked operand sums
    function automatic logic carry_into(input logic [3:0] a, input logic [3:0] b,
                                        input logic c, input int k);
        logic [4:0] m, t;
        m = (5'd1 << k) - 5'd1;
        t = ({1'b0, a} & m) + ({1'b0, b} & m) + {4'd0, c};
        return t[k];
    endfunction

    // driver: apply one vector and queue its expected outputs
    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic c, input string tag);
        item_t it;
        logic [4:0] full;
        @(negedge clk);
        a_i = a; b_i = b; cin_i = c;
        full = {1'b0, a} + {1'b0, b} + {4'd0, c};
        it.exp_sum   = full[3:0];
        it.exp_cout  = full[4];
        it.exp_carry = {carry_into(a, b, c, 3), carry_into(a, b, c, 2), carry_into(a, b, c, 1)};
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: pop and compare at the rising edge after each drive
    always @(posedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_tests++;
            if (sum_o !== it.exp_sum) begin
                n_fail++;
                $display("FAIL %s R1 sum a=%h b=%h c=%b: got %h expected %h",
                         it.tag, a_i, b_i, cin_i, sum_o, it.exp_sum);
            end
            n_tests++;
            if (cout_o !== it.exp_cout) begin
                n_fail++;
                $display("FAIL %s R2 cout a=%h b=%h c=%b: got %b expected %b",
                         it.tag, a_i, b_i, cin_i, cout_o, it.exp_cout);
            end
            n_tests++;
            if (carry_o !== it.exp_carry) begin
                n_fail++;
                $display("FAIL %s R3 carries a=%h b=%h c=%b: got %b expected %b",
                         it.tag, a_i, b_i, cin_i, carry_o, it.exp_carry);
            end
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // idle state: zero inputs give zero outputs (R7)
        drive(4'h0, 4'h0, 1'b0, "R7 idle");
        drive(4'h0, 4'h0, 1'b1, "R7 cin only");
        // generate at every position (R4)
        drive(4'hF, 4'hF, 1'b0, "R4 all generate");
        drive(4'h8, 4'h8, 1'b1, "R4 top generate");
        // kill above a live carry (R5)
        drive(4'h3, 4'h3, 1'b1, "R5 kill bit2");
        drive(4'h7, 4'h0, 1'b1, "R5 kill bit3");
        // propagate passes carry unchanged (R6)
        drive(4'h2, 4'h1, 1'b1, "R6 propagate low");
        drive(4'h4, 4'h3, 1'b0, "R6 propagate no carry");
        // full propagate chain through the split top carry (R8)
        drive(4'h5, 4'hA, 1'b1, "R8 chain from cin");
        drive(4'h5, 4'hA, 1'b0, "R8 chain idle");
        drive(4'hF, 4'h1, 1'b0, "R8 generate bit0 through chain");
        drive(4'hE, 4'h1, 1'b1, "R8 chain mixed");
        // exhaustive sweep (R1 R2 R3)
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    drive(a[3:0], b[3:0], c[0], "R1/R2/R3 sweep");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule